// File: doc/BRIEF.md
# Tightly Coupled Memory Segment Mapper

The block divides one physical pool of tightly coupled memory between an instruction window and a data window. The pool is built from equal segments of 64 KB each, four by default, giving 256 KB in total. A split register holds how many segments belong to the instruction side. The data side gets all the remaining segments. After reset every segment belongs to the data side.

Each side always decodes a full pool-sized window. The instruction window starts at 0x0000_0000 and the data window starts at 0x0800_0000. Three requesters are decoded: the processor instruction side, the processor data side, and a bus master. The bus master can only reach the data window.

A backed access returns a physical segment index and a byte offset inside that segment. An access that lands in the unbacked upper part of a window is a hole. A hole raises a one-cycle interrupt pulse; the instruction side and the data side have separate pulses. A bus access that lands in the data hole is blocked: it returns an error response and pulses a bus-error interrupt.

Top module: `tcm_split_mapper`

## Requirements
- R1: During and after reset, `cfg_split` reads 0, so all segments are data segments. All hit, hole, error, segment and offset outputs read 0 until a request is made.
- R2: A write through `cfg_we` stores `cfg_wdata`, and any value above the segment count (4) is stored as 4. The new value appears on `cfg_split` one cycle after the write. Decodes requested in the same cycle as the write still use the old value. With no write, the value holds.
- R3: An instruction request whose address bits [31:18] match the instruction base (0) is backed when window segment `addr[17:16]` is below the split count. It then returns `i_hit`=1, `i_seg`=`addr[17:16]` and `i_off`=`addr[15:0]`. Segment and offset read 0 whenever the hit is 0.
- R4: An instruction request inside the instruction window whose segment is at or above the split count gives `i_hit`=0 and a single-cycle `irq_i_hole` pulse.
- R5: A data request with bits [31:18] equal to those of 0x0800_0000 is backed when window segment `addr[17:16]` is below 4 minus the split count. It then returns `d_hit`=1, `d_seg`=`addr[17:16]`+split count and `d_off`=`addr[15:0]`. Instruction segments occupy the low physical segments.
- R6: A data request inside the data window but beyond the data size gives `d_hit`=0 and a single-cycle `irq_d_hole` pulse.
- R7: A bus request is decoded against the data window exactly as in R5, and reported on `b_hit`, `b_seg` and `b_off`.
- R8: A bus request in the data hole is blocked. It gives `b_hit`=0, `b_err`=1 and a single-cycle `irq_bus_err` pulse.
- R9: A request outside its window has no effect: no hit, no hole, no error, no interrupt. This includes any bus request into the instruction window.
- R10: Every result is registered. It appears in the cycle after its request, and without a new request it returns to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Split register write strobe |
| cfg_wdata | input | 3 | Requested instruction segment count |
| cfg_split | output | 3 | Current instruction segment count |
| i_req | input | 1 | Instruction-side request |
| i_addr | input | 32 | Instruction-side address |
| i_hit | output | 1 | Instruction access backed |
| i_seg | output | 2 | Instruction physical segment |
| i_off | output | 16 | Instruction segment offset |
| irq_i_hole | output | 1 | Instruction hole interrupt pulse |
| d_req | input | 1 | Data-side request |
| d_addr | input | 32 | Data-side address |
| d_hit | output | 1 | Data access backed |
| d_seg | output | 2 | Data physical segment |
| d_off | output | 16 | Data segment offset |
| irq_d_hole | output | 1 | Data hole interrupt pulse |
| b_req | input | 1 | Bus master request |
| b_addr | input | 32 | Bus master address |
| b_hit | output | 1 | Bus access backed |
| b_seg | output | 2 | Bus physical segment |
| b_off | output | 16 | Bus segment offset |
| b_err | output | 1 | Bus access blocked, error response |
| irq_bus_err | output | 1 | Bus error interrupt pulse |

## Verification
Every decode result and interrupt pulse is due exactly one clock edge after its request. A split write shows on `cfg_split` after the same single edge, while decodes in the write cycle still see the old count. The driver applies one vector per cycle at the falling edge and queues its expectation. The monitor pops one expectation a few nanoseconds after each following rising edge, so every comparison lands in the cycle where the result is due. An idle vector after active ones confirms that the pulses last a single cycle.

// File: rtl/tcm_map_pkg.sv
package tcm_map_pkg;
  typedef enum logic {SIDE_INSTR = 1'b0, SIDE_DATA = 1'b1} side_e;

  // count width able to hold 0..nseg
  function automatic int cnt_width(input int nseg);
    return $clog2(nseg + 1);
  endfunction
endpackage

// File: rtl/tcm_split_reg.sv
module tcm_split_reg #(
  parameter int NSEG  = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(NSEG);

  logic [CNT_W-1:0] clamped;
  assign clamped = (wdata > MAXC) ? MAXC : wdata;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (we) cnt_q <= clamped;
  end

  AST_SPLIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAXC); // R2
  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/tcm_win_decoder.sv
module tcm_win_decoder
  import tcm_map_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              SEG_AW = 16,
  parameter int              NSEG   = 4,
  parameter int              CNT_W  = 3,
  parameter side_e           SIDE   = SIDE_DATA,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CNT_W-1:0]           icnt,
  output logic                       hit_q,
  output logic                       hole_q,
  output logic [$clog2(NSEG)-1:0]    seg_q,
  output logic [SEG_AW-1:0]          off_q
);
  localparam int SEL_W  = $clog2(NSEG);
  localparam int WIN_AW = SEG_AW + SEL_W;

  logic             in_win, backed;
  logic [SEL_W-1:0] sel, phys;
  logic [CNT_W-1:0] sel_ext;

  assign in_win  = (addr[ADDR_W-1:WIN_AW] == BASE[ADDR_W-1:WIN_AW]);
  assign sel     = addr[WIN_AW-1:SEG_AW];
  assign sel_ext = CNT_W'(sel);

  generate
    if (SIDE == SIDE_INSTR) begin : g_instr
      // instruction segments sit at the bottom of the pool
      assign backed = (sel_ext < icnt);
      assign phys   = sel;
    end else begin : g_data
      // data segments follow the instruction segments
      assign backed = (sel_ext < (CNT_W'(NSEG) - icnt));
      assign phys   = sel + icnt[SEL_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      hole_q <= 1'b0;
      seg_q  <= '0;
      off_q  <= '0;
    end else begin
      hit_q  <= req && in_win && backed;
      hole_q <= req && in_win && !backed;
      seg_q  <= (req && in_win && backed) ? phys : '0;
      off_q  <= (req && in_win && backed) ? addr[SEG_AW-1:0] : '0;
    end
  end

  AST_HIT_HOLE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hit_q && hole_q)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!hit_q && !hole_q)); // R10

  generate
    if (SIDE == SIDE_INSTR) begin : g_chk_i
      AST_INSTR_LOW_SEG: assert property (@(posedge clk) disable iff (rst)
        req |=> (!hit_q || (CNT_W'(seg_q) < $past(icnt)))); // R3
    end else begin : g_chk_d
      AST_DATA_HIGH_SEG: assert property (@(posedge clk) disable iff (rst)
        req |=> (!hit_q || (CNT_W'(seg_q) >= $past(icnt)))); // R5
    end
  endgenerate
endmodule

// File: rtl/tcm_split_mapper.sv
module tcm_split_mapper
  import tcm_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_AW = 16,
  parameter int NSEG   = 4,
  parameter logic [ADDR_W-1:0] I_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] D_BASE = 32'h0800_0000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [$clog2(NSEG+1)-1:0]     cfg_wdata,
  output logic [$clog2(NSEG+1)-1:0]     cfg_split,
  input  logic                          i_req,
  input  logic [ADDR_W-1:0]             i_addr,
  output logic                          i_hit,
  output logic [$clog2(NSEG)-1:0]       i_seg,
  output logic [SEG_AW-1:0]             i_off,
  output logic                          irq_i_hole,
  input  logic                          d_req,
  input  logic [ADDR_W-1:0]             d_addr,
  output logic                          d_hit,
  output logic [$clog2(NSEG)-1:0]       d_seg,
  output logic [SEG_AW-1:0]             d_off,
  output logic                          irq_d_hole,
  input  logic                          b_req,
  input  logic [ADDR_W-1:0]             b_addr,
  output logic                          b_hit,
  output logic [$clog2(NSEG)-1:0]       b_seg,
  output logic [SEG_AW-1:0]             b_off,
  output logic                          b_err,
  output logic                          irq_bus_err
);
  localparam int CNT_W = cnt_width(NSEG);

  logic b_hole;

  tcm_split_reg #(.NSEG(NSEG), .CNT_W(CNT_W)) u_split (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cnt_q(cfg_split)
  );

  tcm_win_decoder #(.ADDR_W(ADDR_W), .SEG_AW(SEG_AW), .NSEG(NSEG), .CNT_W(CNT_W),
                    .SIDE(SIDE_INSTR), .BASE(I_BASE)) u_idec (
    .clk(clk), .rst(rst), .req(i_req), .addr(i_addr), .icnt(cfg_split),
    .hit_q(i_hit), .hole_q(irq_i_hole), .seg_q(i_seg), .off_q(i_off)
  );

  tcm_win_decoder #(.ADDR_W(ADDR_W), .SEG_AW(SEG_AW), .NSEG(NSEG), .CNT_W(CNT_W),
                    .SIDE(SIDE_DATA), .BASE(D_BASE)) u_ddec (
    .clk(clk), .rst(rst), .req(d_req), .addr(d_addr), .icnt(cfg_split),
    .hit_q(d_hit), .hole_q(irq_d_hole), .seg_q(d_seg), .off_q(d_off)
  );

  // bus master sees only the data window
  tcm_win_decoder #(.ADDR_W(ADDR_W), .SEG_AW(SEG_AW), .NSEG(NSEG), .CNT_W(CNT_W),
                    .SIDE(SIDE_DATA), .BASE(D_BASE)) u_bdec (
    .clk(clk), .rst(rst), .req(b_req), .addr(b_addr), .icnt(cfg_split),
    .hit_q(b_hit), .hole_q(b_hole), .seg_q(b_seg), .off_q(b_off)
  );

  assign b_err       = b_hole;
  assign irq_bus_err = b_hole;

  AST_BUS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !(b_hit && b_err)); // R8
  AST_BUS_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_bus_err |-> $past(b_req)); // R10
endmodule

// File: tb/sim_tcm_split_mapper.sv
`timescale 1ns/1ps
module sim_tcm_split_mapper;
  typedef struct {
    string      tag;
    logic [2:0] split;
    logic [19:0] iv;
    logic [19:0] dv;
    logic [20:0] bv;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0, cfg_split;
  logic i_req = 1'b0, d_req = 1'b0, b_req = 1'b0;
  logic [31:0] i_addr = '0, d_addr = '0, b_addr = '0;
  logic i_hit, d_hit, b_hit, irq_i_hole, irq_d_hole, b_err, irq_bus_err;
  logic [1:0] i_seg, d_seg, b_seg;
  logic [15:0] i_off, d_off, b_off;

  int nvec = 0, nbad = 0;
  int mcnt = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  tcm_split_mapper u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_split(cfg_split),
    .i_req(i_req), .i_addr(i_addr), .i_hit(i_hit), .i_seg(i_seg), .i_off(i_off),
    .irq_i_hole(irq_i_hole),
    .d_req(d_req), .d_addr(d_addr), .d_hit(d_hit), .d_seg(d_seg), .d_off(d_off),
    .irq_d_hole(irq_d_hole),
    .b_req(b_req), .b_addr(b_addr), .b_hit(b_hit), .b_seg(b_seg), .b_off(b_off),
    .b_err(b_err), .irq_bus_err(irq_bus_err)
  );

  // requirement model: {hit, hole, seg, off}
  function automatic logic [19:0] model(input bit instr, input logic req,
                                        input logic [31:0] a, input int cnt);
    logic [31:0] base = instr ? 32'h0 : 32'h0800_0000;
    int sel = int'(a[17:16]);
    bit inwin = req && (a[31:18] == base[31:18]);
    bit backed = instr ? (sel < cnt) : (sel < 4 - cnt);
    int phys = instr ? sel : sel + cnt;
    bit hit = inwin && backed;
    bit hole = inwin && !backed;
    logic [1:0] ps = 2'(phys);
    return {hit, hole, hit ? ps : 2'b00, hit ? a[15:0] : 16'h0};
  endfunction

  task automatic apply(input string tag, input logic we, input logic [2:0] wd,
                       input logic ir, input logic [31:0] ia,
                       input logic dr, input logic [31:0] da,
                       input logic br, input logic [31:0] ba);
    exp_t e;
    logic [19:0] bm;
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd;
    i_req = ir; i_addr = ia; d_req = dr; d_addr = da; b_req = br; b_addr = ba;
    e.tag = tag;
    e.iv = model(1'b1, ir, ia, mcnt);
    e.dv = model(1'b0, dr, da, mcnt);
    bm   = model(1'b0, br, ba, mcnt);
    e.bv = {bm[19], bm[18], bm[18], bm[17:0]};
    if (we) mcnt = (int'(wd) > 4) ? 4 : int'(wd);
    e.split = 3'(mcnt);
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    apply(tag, 1'b0, 3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  // monitor: result due one rising edge after the vector
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      logic [19:0] ai, ad;
      logic [20:0] ab;
      e = q.pop_front();
      ai = {i_hit, irq_i_hole, i_seg, i_off};
      ad = {d_hit, irq_d_hole, d_seg, d_off};
      ab = {b_hit, b_err, irq_bus_err, b_seg, b_off};
      nvec++;
      if (ai !== e.iv || ad !== e.dv || ab !== e.bv || cfg_split !== e.split) begin
        nbad++;
        $display("FAIL %s: i=%h/%h d=%h/%h b=%h/%h split=%0d/%0d (actual/expected)",
                 e.tag, ai, e.iv, ad, e.dv, ab, e.bv, cfg_split, e.split);
      end
    end
  end

  initial begin
    #4_000_000;
    nbad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    nvec++;
    if ({cfg_split, i_hit, irq_i_hole, i_seg, i_off, d_hit, irq_d_hole, d_seg, d_off,
         b_hit, b_err, irq_bus_err, b_seg, b_off} !== '0) begin
      nbad++;
      $display("FAIL R1: reset outputs actual=%0d/%b expected=0/0", cfg_split, {i_hit, d_hit, b_hit});
    end
    rst = 1'b0;
    // R1 all-data after reset, R5/R7 decode, R4 instruction hole
    apply("R1_R5", 1'b0, 3'd0, 1'b1, 32'h0000_0010, 1'b1, 32'h0803_1234, 1'b1, 32'h0801_00AB);
    idle("R10");
    // R2 clamp
    apply("R2_clamp", 1'b1, 3'd7, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    apply("R3_R6_R8", 1'b0, 3'd0, 1'b1, 32'h0003_FFFF, 1'b1, 32'h0800_0004, 1'b1, 32'h0800_0000);
    // R2 write with same-cycle decode on old count
    apply("R2_oldcnt", 1'b1, 3'd1, 1'b1, 32'h0001_0000, 1'b1, 32'h0802_0004, 1'b1, 32'h0800_1111);
    apply("R3_R5_R7", 1'b0, 3'd0, 1'b1, 32'h0000_FFFF, 1'b1, 32'h0802_0004, 1'b1, 32'h0800_1111);
    apply("R4_R6", 1'b0, 3'd0, 1'b1, 32'h0001_0000, 1'b1, 32'h0803_0000, 1'b0, 32'h0);
    apply("R2_write3", 1'b1, 3'd3, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    apply("R5_R8", 1'b0, 3'd0, 1'b1, 32'h0002_8000, 1'b1, 32'h0800_5555, 1'b1, 32'h0801_0000);
    // R9: outside windows, bus into instruction window
    apply("R9", 1'b0, 3'd0, 1'b1, 32'h0004_0000, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0000);
    apply("R9_bus", 1'b0, 3'd0, 1'b1, 32'h0800_0000, 1'b1, 32'h0804_0000, 1'b1, 32'h07FF_FFFF);
    idle("R10_pulse_end");
    // sweep every split and every window segment
    for (int c = 0; c <= 5; c++) begin
      apply("R2_sweep", 1'b1, 3'(c), 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
      for (int s = 0; s < 4; s++) begin
        logic [31:0] off = 32'(s * 16'h1357 + c);
        apply("R3/R4/R5/R6/R7/R8 sweep", 1'b0, 3'd0,
              1'b1, {14'h0, 2'(s), off[15:0]},
              1'b1, {14'h0200, 2'(s), off[15:0]},
              1'b1, {14'h0200, 2'(3 - s), off[15:0]});
      end
      idle("R10");
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule